// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block sends pairs of 18-bit two's complement samples, one for the left channel and one for the right, as a serial stream on one data line. The stream is framed by a bit clock and a word-select clock. Everything runs from a single master clock. A pair is offered on a parallel bus together with a one-cycle valid strobe. The block keeps the most recent pair and starts sending it at the next left half-frame. The right value that follows is always the partner of the left value that was just sent.

There are two clocking modes. In master mode the block makes its own bit clock by dividing the master clock by 4, 6 or 8. These divisors give master-to-frame ratios of 256, 384 and 512, because every frame holds 64 bit periods. The block also makes the word-select clock. In slave mode the block takes both clocks from outside. It samples them in the master-clock domain and starts a new channel word at each word-select edge, whatever the duty cycle of that clock. In both modes the data changes only where the bit clock falls. Each word is sent most significant bit first, and the remaining bit slots of the half-frame are sent as zero.

Top module: `audio_serial_tx`

## Requirements
- R1: In master mode, `sclk_out` has a period of 4, 6 or 8 `mclk` cycles for `ratio_sel` 0, 1 and 2, and the value 3 gives the same as 2. `sclk_out` is high and low for equal numbers of `mclk` cycles: 2, 3 or 4.
- R2: In master mode, `lrck_out` changes level after every 32 rising edges of `sclk_out`. Low means the left channel and high means the right channel.
- R3: In master mode, `lrck_out` and `sdata` change only on the `mclk` edge where `sclk_out` goes from high to low.
- R4: A half-frame starts with a word-select edge. It carries its 18-bit sample on `sdata`, starting with bit 17 on the first slot and ending with bit 0 on slot 17. Every later slot of that half-frame carries 0.
- R5: When `smp_valid` is high, the block captures `smp_left` and `smp_right` together. A left half-frame sends the most recent captured pair, and a pair whose strobe is high in the same `mclk` cycle as the left start counts as most recent. The right half-frame that follows sends the right value of that same pair, even if a new pair arrives during the left half-frame.
- R6: While `rst_n` is low, `sclk_out` is 0, `lrck_out` is 1 and `sdata` is 0. In master mode, the first word-select change after reset starts a left half-frame.
- R7: In slave mode, each edge of `lrck_in` starts a channel word. The new level of `lrck_in` selects the channel. The word's bit 17 appears on `sdata` by the third rising edge of `mclk` after the edge. Each later falling edge of `sclk_in` moves the output to the next slot. A right word that comes before any left start carries zeros.
- R8: In slave mode, half-frames may be of unequal length (word-select duty from 25% to 75%). A short half-frame sends only the bits that fit, and a long one pads with zeros.
- R9: In slave mode, `sclk_out` is held at 0 and `lrck_out` is held at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock; all logic is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | 0: block drives bit and word-select clocks; 1: they come from `sclk_in` and `lrck_in` |
| ratio_sel | input | 2 | Master-to-frame ratio: 0 gives 256, 1 gives 384, 2 or 3 gives 512 |
| smp_valid | input | 1 | One-cycle strobe that captures a sample pair |
| smp_left | input | 18 | Left sample, two's complement |
| smp_right | input | 18 | Right sample, two's complement |
| sclk_in | input | 1 | External bit clock, used in slave mode |
| lrck_in | input | 1 | External word-select clock, used in slave mode |
| sclk_out | output | 1 | Generated bit clock (master mode) |
| lrck_out | output | 1 | Generated word-select clock (master mode) |
| sdata | output | 1 | Serial data output |

## Verification
Capturing a new pair and starting a left half-frame can happen in the same `mclk` cycle. The bench provokes this in slave mode, where it controls the word-select edge and knows the cycle in which the synchronized edge reaches the shifter. It raises the strobe exactly in that cycle and expects the new pair to be sent at once. It then raises the strobe one cycle later and expects the old pair now and the new pair only in the next frame. In master mode, randomly timed strobes sometimes land on a frame start. A bench model judges every half-frame, and this model applies the strobe seen at the same clock edge before it picks the pair.

// File: rtl/audtx_pkg.sv
package audtx_pkg;

  typedef enum logic [1:0] {
    RATIO_256     = 2'd0,
    RATIO_384     = 2'd1,
    RATIO_512     = 2'd2,
    RATIO_512_ALT = 2'd3
  } ratio_e;

  typedef enum logic {
    CLK_MASTER = 1'b0,
    CLK_SLAVE  = 1'b1
  } clk_mode_e;

  localparam int DIV_CNT_W = 2;

  // Half bit-clock period in master-clock cycles, minus one.
  function automatic logic [DIV_CNT_W-1:0] half_limit(input logic [1:0] sel);
    logic [DIV_CNT_W-1:0] lim;
    case (ratio_e'(sel))
      RATIO_256: lim = 2'd1;
      RATIO_384: lim = 2'd2;
      default:   lim = 2'd3;
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/audtx_master_gen.sv
module audtx_master_gen
  import audtx_pkg::*;
#(
  parameter int SLOT_CNT = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] ratio_sel,
  output logic       sclk_o,
  output logic       lrck_o,
  output logic       ev_start_o,
  output logic       ev_bit_o,
  output logic       ev_chan_o
);

  localparam int SLOT_W = $clog2(SLOT_CNT);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_CNT - 1);
  localparam int RUN_W = DIV_CNT_W + 1;

  logic [DIV_CNT_W-1:0] cnt_q, cnt_d, lim;
  logic [SLOT_W-1:0]    slot_q, slot_d;
  logic                 sclk_q, sclk_d;
  logic                 lrck_q, lrck_d;
  logic                 tick, fall, wrap;

  // next state
  always_comb begin
    lim    = half_limit(ratio_sel);
    tick   = en & (cnt_q >= lim);
    fall   = tick & sclk_q;
    wrap   = (slot_q == SLOT_LAST);
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    lrck_d = lrck_q;
    slot_d = slot_q;
    if (!en) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
      lrck_d = 1'b1;
      slot_d = SLOT_LAST;
    end else begin
      if (tick) begin
        cnt_d  = '0;
        sclk_d = ~sclk_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      if (fall) begin
        slot_d = wrap ? '0 : slot_q + 1'b1;
        if (wrap) lrck_d = ~lrck_q;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
      lrck_q <= 1'b1;
      slot_q <= SLOT_LAST;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
      lrck_q <= lrck_d;
      slot_q <= slot_d;
    end
  end

  assign sclk_o     = sclk_q;
  assign lrck_o     = lrck_q;
  assign ev_start_o = fall & wrap;
  assign ev_bit_o   = fall & ~wrap;
  assign ev_chan_o  = ~lrck_q;

  // Level-length tracker for the duty check.
  logic [RUN_W-1:0] run_q, run_d;
  logic [1:0]       ratio_q;
  logic             clean_q, clean_d;

  always_comb begin
    run_d   = run_q;
    clean_d = clean_q;
    if (!en || (sclk_d != sclk_q)) begin
      run_d   = '0;
      clean_d = 1'b1;
    end else if (run_q != '1) begin
      run_d = run_q + 1'b1;
    end
    if (en && (ratio_sel != ratio_q)) clean_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      clean_q <= 1'b1;
      ratio_q <= 2'd0;
    end else begin
      run_q   <= run_d;
      clean_q <= clean_d;
      ratio_q <= ratio_sel;
    end
  end

  AST_SCLK_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (sclk_d != sclk_q) && clean_q && (ratio_sel == ratio_q)) |-> (run_q == RUN_W'(lim))) // R1
    else $error("bit clock level length wrong");

  AST_LRCK_ON_SCLK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && (lrck_q != $past(lrck_q))) |-> $fell(sclk_q)) // R3
    else $error("word select moved off a bit clock fall");

endmodule

// File: rtl/audtx_slave_sync.sv
module audtx_slave_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic lrck_i,
  output logic ev_start_o,
  output logic ev_bit_o,
  output logic ev_chan_o
);

  logic [STAGES-1:0] sck_sync_q, lrk_sync_q;
  logic              sck_prev_q, lrk_prev_q;
  logic              sck_s, lrk_s, ledge, sfall;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            sck_sync_q[0] <= 1'b0;
            lrk_sync_q[0] <= 1'b0;
          end else begin
            sck_sync_q[0] <= sclk_i;
            lrk_sync_q[0] <= lrck_i;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            sck_sync_q[g] <= 1'b0;
            lrk_sync_q[g] <= 1'b0;
          end else begin
            sck_sync_q[g] <= sck_sync_q[g-1];
            lrk_sync_q[g] <= lrk_sync_q[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev_q <= 1'b0;
      lrk_prev_q <= 1'b0;
    end else begin
      sck_prev_q <= sck_s;
      lrk_prev_q <= lrk_s;
    end
  end

  always_comb begin
    sck_s = sck_sync_q[STAGES-1];
    lrk_s = lrk_sync_q[STAGES-1];
    ledge = lrk_s ^ lrk_prev_q;
    sfall = sck_prev_q & ~sck_s;
  end

  // A word-select edge takes precedence over a coincident bit clock fall.
  assign ev_start_o = ledge;
  assign ev_bit_o   = sfall & ~ledge;
  assign ev_chan_o  = lrk_s;

endmodule

// File: rtl/audtx_shifter.sv
module audtx_shifter #(
  parameter int SMP_W    = 18,
  parameter int SLOT_CNT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_start_i,
  input  logic             ev_bit_i,
  input  logic             ev_chan_i,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_left_i,
  input  logic [SMP_W-1:0] smp_right_i,
  output logic             sdata_o
);

  localparam int BIT_W = $clog2(SLOT_CNT + 1);

  logic [SMP_W-1:0] pend_l_q, pend_l_d, pend_r_q, pend_r_d;
  logic [SMP_W-1:0] hold_r_q, hold_r_d;
  logic [SMP_W-1:0] sh_q, sh_d, word;
  logic             sdata_q, sdata_d;

  // next state
  always_comb begin
    pend_l_d = smp_valid_i ? smp_left_i  : pend_l_q;
    pend_r_d = smp_valid_i ? smp_right_i : pend_r_q;
    hold_r_d = hold_r_q;
    sh_d     = sh_q;
    sdata_d  = sdata_q;
    word     = ev_chan_i ? hold_r_q : pend_l_d;
    if (ev_start_i) begin
      if (!ev_chan_i) hold_r_d = pend_r_d;
      sdata_d = word[SMP_W-1];
      sh_d    = {word[SMP_W-2:0], 1'b0};
    end else if (ev_bit_i) begin
      sdata_d = sh_q[SMP_W-1];
      sh_d    = {sh_q[SMP_W-2:0], 1'b0};
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_l_q <= '0;
      pend_r_q <= '0;
      hold_r_q <= '0;
      sh_q     <= '0;
      sdata_q  <= 1'b0;
    end else begin
      pend_l_q <= pend_l_d;
      pend_r_q <= pend_r_d;
      hold_r_q <= hold_r_d;
      sh_q     <= sh_d;
      sdata_q  <= sdata_d;
    end
  end

  assign sdata_o = sdata_q;

  // Slot counter for the zero-tail check.
  logic [BIT_W-1:0] slot_q, slot_d;

  always_comb begin
    slot_d = slot_q;
    if (ev_start_i)                           slot_d = '0;
    else if (ev_bit_i && (slot_q != '1))      slot_d = slot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '1;
    else        slot_q <= slot_d;
  end

  AST_ZERO_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q >= BIT_W'(SMP_W)) |-> !sdata_q) // R4
    else $error("nonzero data past the sample bits");

  AST_SDATA_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata_q != $past(sdata_q)) |-> $past(ev_start_i || ev_bit_i)) // R3
    else $error("data moved without a slot event");

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
  import audtx_pkg::*;
#(
  parameter int SMP_W       = 18,
  parameter int SLOT_CNT    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic             slave_mode,
  input  logic [1:0]       ratio_sel,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_left,
  input  logic [SMP_W-1:0] smp_right,
  input  logic             sclk_in,
  input  logic             lrck_in,
  output logic             sclk_out,
  output logic             lrck_out,
  output logic             sdata
);

  clk_mode_e mode;
  logic m_start, m_bit, m_chan;
  logic s_start, s_bit, s_chan;
  logic ev_start, ev_bit, ev_chan;

  assign mode = clk_mode_e'(slave_mode);

  audtx_master_gen #(
    .SLOT_CNT (SLOT_CNT)
  ) u_gen (
    .clk        (mclk),
    .rst_n      (rst_n),
    .en         (mode == CLK_MASTER),
    .ratio_sel  (ratio_sel),
    .sclk_o     (sclk_out),
    .lrck_o     (lrck_out),
    .ev_start_o (m_start),
    .ev_bit_o   (m_bit),
    .ev_chan_o  (m_chan)
  );

  audtx_slave_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk        (mclk),
    .rst_n      (rst_n),
    .sclk_i     (sclk_in),
    .lrck_i     (lrck_in),
    .ev_start_o (s_start),
    .ev_bit_o   (s_bit),
    .ev_chan_o  (s_chan)
  );

  always_comb begin
    if (mode == CLK_SLAVE) begin
      ev_start = s_start;
      ev_bit   = s_bit;
      ev_chan  = s_chan;
    end else begin
      ev_start = m_start;
      ev_bit   = m_bit;
      ev_chan  = m_chan;
    end
  end

  audtx_shifter #(
    .SMP_W    (SMP_W),
    .SLOT_CNT (SLOT_CNT)
  ) u_shift (
    .clk         (mclk),
    .rst_n       (rst_n),
    .ev_start_i  (ev_start),
    .ev_bit_i    (ev_bit),
    .ev_chan_i   (ev_chan),
    .smp_valid_i (smp_valid),
    .smp_left_i  (smp_left),
    .smp_right_i (smp_right),
    .sdata_o     (sdata)
  );

  AST_SLAVE_CLOCKS_QUIET: assert property (@(posedge mclk) disable iff (!rst_n)
    slave_mode |=> (!sclk_out && lrck_out)) // R9
    else $error("generated clocks active in slave mode");

endmodule

// File: tb/audio_serial_tx_tb.sv
module audio_serial_tx_tb_top;

  localparam int SW    = 18;
  localparam int SLOTS = 32;
  localparam int PAD   = SLOTS - SW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          slave_mode;
  logic [1:0]    ratio_sel;
  logic          smp_valid;
  logic [SW-1:0] smp_left, smp_right;
  logic          sclk_in, lrck_in;
  logic          sclk_out, lrck_out, sdata;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;

  logic [SW-1:0] m_lat_l, m_lat_r, m_act_r;

  always #5 clk = ~clk;

  audio_serial_tx dut_i (
    .mclk       (clk),
    .rst_n      (rst_n),
    .slave_mode (slave_mode),
    .ratio_sel  (ratio_sel),
    .smp_valid  (smp_valid),
    .smp_left   (smp_left),
    .smp_right  (smp_right),
    .sclk_in    (sclk_in),
    .lrck_in    (lrck_in),
    .sclk_out   (sclk_out),
    .lrck_out   (lrck_out),
    .sdata      (sdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int half_of(input logic [1:0] sel);
    if (sel == 2'd0) return 2;
    if (sel == 2'd1) return 3;
    return 4;
  endfunction

  function automatic logic slot_bit(input logic [SW-1:0] w, input int slot);
    if (slot < SW) return w[SW-1-slot];
    return 1'b0;
  endfunction

  task automatic do_reset();
    rst_n     = 1'b0;
    smp_valid = 1'b0;
    smp_left  = '0;
    smp_right = '0;
    sclk_in   = 1'b0;
    lrck_in   = 1'b0;
    m_lat_l   = '0;
    m_lat_r   = '0;
    m_act_r   = '0;
    repeat (3) @(negedge clk);
    check(!sclk_out && lrck_out && !sdata, "R6", "outputs in reset",
          {sclk_out, lrck_out, sdata}, 3'b010);
    rst_n = 1'b1;
  endtask

  task automatic run_master(input logic [1:0] sel, input int halves);
    int h;
    int run;
    int nb;
    int seen;
    int guard;
    bit first_tog;
    bit open;
    bit cv;
    logic s, l, d, ps, pl, pd;
    logic [SLOTS-1:0] got, expw;
    logic [SW-1:0] cl, cr;
    logic [31:0] rnd;
    h = half_of(sel);
    ratio_sel  = sel;
    slave_mode = 1'b0;
    do_reset();
    ps = 1'b0; pl = 1'b1; pd = 1'b0;
    run = 0; nb = 0; seen = 0; guard = 0;
    first_tog = 1; open = 0; cv = 0;
    got = '0; expw = '0; cl = '0; cr = '0;
    while (seen < halves && guard < 30000) begin
      @(negedge clk);
      guard++;
      if (cv) begin m_lat_l = cl; m_lat_r = cr; end
      s = sclk_out; l = lrck_out; d = sdata;
      if (s != ps) begin
        if (!first_tog) check(run == h, "R1", "bit clock level length", run, h);
        first_tog = 0;
        run = 1;
      end else begin
        run++;
      end
      if (l != pl) check(ps && !s, "R3", "word select moved off a fall", {ps, s}, 2'b10);
      if (d != pd) check(ps && !s, "R3", "data moved off a fall", {ps, s}, 2'b10);
      if (!ps && s && open) begin
        got = {got[SLOTS-2:0], d};
        nb++;
      end
      if (l != pl) begin
        if (!open) check(l == 1'b0, "R6", "first half after reset is left", l, 0);
        if (open) begin
          check(nb == SLOTS, "R2", "bit clocks per half-frame", nb, SLOTS);
          check(got == expw, "R4 R5", "half-frame word", got, expw);
          seen++;
        end
        if (l == 1'b0) begin
          m_act_r = m_lat_r;
          expw    = {m_lat_l, {PAD{1'b0}}};
        end else begin
          expw    = {m_act_r, {PAD{1'b0}}};
        end
        open = 1; nb = 0; got = '0;
      end
      ps = s; pl = l; pd = d;
      cv = ($urandom_range(0, 99) < 3);
      if (cv) begin
        rnd = $urandom; cl = rnd[SW-1:0];
        rnd = $urandom; cr = rnd[SW-1:0];
      end
      smp_valid = cv;
      smp_left  = cl;
      smp_right = cr;
    end
    smp_valid = 1'b0;
    check(seen == halves, "R2", "half-frames observed", seen, halves);
  endtask

  task automatic pulse_pair(input logic [SW-1:0] nl, input logic [SW-1:0] nr);
    smp_valid = 1'b1; smp_left = nl; smp_right = nr;
    @(negedge clk);
    smp_valid = 1'b0;
    m_lat_l = nl; m_lat_r = nr;
    @(negedge clk);
  endtask

  // mode: 0 none, 1 strobe on the start cycle, 2 strobe one cycle late, 3 strobe mid-word
  task automatic slave_half(input logic ch, input int nslots, input int mode,
                            input logic [SW-1:0] nl, input logic [SW-1:0] nr);
    logic [SW-1:0] word;
    logic [SLOTS-1:0] gotv, expv;
    int bad;
    bit trig;
    if (ch == 1'b0) begin
      if (mode == 1) begin
        word = nl; m_act_r = nr;
      end else begin
        word = m_lat_l; m_act_r = m_lat_r;
      end
    end else begin
      word = m_act_r;
    end
    bad = 0; gotv = '0; expv = '0;
    for (int slot = 0; slot < nslots; slot++) begin
      sclk_in = 1'b0;
      if (slot == 0) lrck_in = ch;
      for (int k = 1; k <= 4; k++) begin
        @(negedge clk);
        trig = (mode == 1 && slot == 0 && k == 2) ||
               (mode == 2 && slot == 0 && k == 3) ||
               (mode == 3 && slot == 5 && k == 2);
        smp_valid = trig;
        smp_left  = nl;
        smp_right = nr;
        if (k == 4) begin
          if (slot < SLOTS) begin
            gotv[SLOTS-1-slot] = sdata;
            expv[SLOTS-1-slot] = slot_bit(word, slot);
          end
          if (sdata !== slot_bit(word, slot)) bad++;
        end
      end
      sclk_in = 1'b1;
      repeat (4) @(negedge clk);
    end
    if (mode != 0) begin m_lat_l = nl; m_lat_r = nr; end
    check(bad == 0, (nslots == SLOTS) ? "R7" : "R8", "slave half-frame word", gotv, expv);
    check(!sclk_out && lrck_out, "R9", "generated clocks quiet", {sclk_out, lrck_out}, 2'b01);
  endtask

  task automatic run_slave();
    logic [31:0] rnd;
    logic [SW-1:0] a_l, a_r;
    int len;
    int md;
    slave_mode = 1'b1;
    ratio_sel  = 2'd0;
    do_reset();
    @(negedge clk);
    // right word before any left start: zeros
    slave_half(1'b1, 20, 0, '0, '0);
    pulse_pair(18'h2A5C3, 18'h15A3C);
    slave_half(1'b0, 32, 0, '0, '0);
    slave_half(1'b1, 32, 0, '0, '0);
    // R5 strobe in the start cycle: new pair goes out now
    slave_half(1'b0, 32, 1, 18'h3FFFF, 18'h20001);
    slave_half(1'b1, 32, 0, '0, '0);
    // R5 strobe one cycle late: old pair now, new pair next frame
    slave_half(1'b0, 24, 2, 18'h1C0DE, 18'h0BEEF);
    slave_half(1'b1, 40, 0, '0, '0);
    // R5 strobe during the left word: right still from the left start
    slave_half(1'b0, 40, 3, 18'h12345, 18'h3ABCD);
    slave_half(1'b1, 24, 0, '0, '0);
    // R8 75% duty: right word truncated to 16 slots
    slave_half(1'b0, 48, 0, '0, '0);
    slave_half(1'b1, 16, 0, '0, '0);
    for (int f = 0; f < 8; f++) begin
      rnd = $urandom; a_l = rnd[SW-1:0];
      rnd = $urandom; a_r = rnd[SW-1:0];
      len = $urandom_range(20, 44);
      md  = $urandom_range(0, 3);
      slave_half(1'b0, len, md, a_l, a_r);
      slave_half(1'b1, 64 - len, 0, '0, '0);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n      = 1'b0;
    slave_mode = 1'b0;
    ratio_sel  = 2'd0;
    smp_valid  = 1'b0;
    smp_left   = '0;
    smp_right  = '0;
    sclk_in    = 1'b0;
    lrck_in    = 1'b0;
    run_master(2'd0, 10);
    run_master(2'd1, 10);
    run_master(2'd2, 10);
    run_master(2'd3, 6);
    run_slave();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule